// File: doc/BRIEF.md
# Receive-Entry Sequencer

This block steps a transceiver from a quiet state into active reception in a fixed order. The order is: synthesizer oscillator calibration, then a counted wait for the frequency synthesizer to settle, then the receive front-end (low-noise amplifier, mixers and converter) switched on together, and last the modem's receive mode. The analog circuits and the modem are represented only by enable outputs. Calibration completion and end of reception arrive as handshake inputs.

Each start command carries a two-bit selector, captured when the command is accepted. That selector decides where the block goes when reception ends. It can return to idle, park in a ready state with only the synthesizer running, run the whole entry sequence again, or go to sleep with everything off. An abort input collapses any active state back to idle and drops every enable at once. A calibration watchdog and a misuse flag report faults as sticky bits that only reset clears.

Top module: `rx_entry_seq`

## Requirements
- R1: After reset, `state_o` is 0 (idle), all six enables are low, and `busy`, `cmd_err` and `cal_err` are low.
- R2: A `start_req` seen in idle (0), ready (5) or sleep (6) moves the block to calibrate (code 1) on the next clock. In calibrate only `synth_en` and `vco_cal_en` are high.
- R3: `cal_done` in calibrate moves the block to settle (code 2) and loads `settle_len`. Settle lasts `settle_len`+1 cycles, so a length of zero gives one cycle. Only `synth_en` is high during settle.
- R4: After settle comes one front-end cycle (code 3). In it `synth_en`, `lna_en`, `mixer_en` and `adc_en` are high and `modem_rx_en` is low. Then comes receive (code 4), where `modem_rx_en` is also high.
- R5: `rx_finish` in receive follows the captured `start_next` selector. 0 goes to idle (code 0). 1 goes to ready (code 5, only `synth_en` high). 2 goes back to calibrate (code 1). 3 goes to sleep (code 6, all enables low). `rx_finish` has no effect in any other state.
- R6: `abort_req` in any state other than idle forces all enables low in the same cycle, and the block is in idle on the next clock. In idle, `abort_req` has no effect.
- R7: `start_req` in calibrate, settle, front-end or receive is ignored and sets `cmd_err`. The state and the captured selector stay unchanged. `cmd_err` stays high until reset.
- R8: If `cal_done` has not arrived after `CAL_TMO` cycles in calibrate, the block goes to idle and sets `cal_err`, which stays high until reset. A `cal_done` in the last allowed cycle still proceeds to settle.
- R9: `busy` is high exactly in states 1 to 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_req | input | 1 | Start-receive command strobe |
| start_next | input | 2 | Post-receive state selector carried with the command |
| settle_len | input | SETTLE_W | Settle wait length in cycles, minus one |
| cal_done | input | 1 | Oscillator calibration finished |
| rx_finish | input | 1 | Reception finished (packet done) |
| abort_req | input | 1 | Abort back to idle |
| synth_en | output | 1 | Synthesizer enable |
| vco_cal_en | output | 1 | Oscillator calibration strobe |
| lna_en | output | 1 | Low-noise amplifier enable |
| mixer_en | output | 1 | Mixer enable |
| adc_en | output | 1 | Converter enable |
| modem_rx_en | output | 1 | Modem receive-mode enable |
| state_o | output | 3 | Current state code |
| busy | output | 1 | Sequence or reception in progress |
| cmd_err | output | 1 | Sticky: start seen while busy |
| cal_err | output | 1 | Sticky: calibration timeout |

## Verification
The bench builds the block with `SETTLE_W` = 5 and `CAL_TMO` = 8. The narrow settle field lets the bench reach both ends of the wait range in a few dozen cycles: the one-cycle wait at zero and the full 32-cycle wait at the all-ones value. The short calibration limit lets the bench hit the watchdog expiry exactly, and also the case where completion lands in the last allowed cycle, without long idle runs.

// File: rtl/rx_seq_pkg.sv
package rx_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_CAL    = 3'd1,
      ST_SETTLE = 3'd2,
      ST_FRONT  = 3'd3,
      ST_RX     = 3'd4,
      ST_READY  = 3'd5,
      ST_SLEEP  = 3'd6
   } seq_state_t;

   typedef enum logic [1:0] {
      NX_IDLE  = 2'd0,
      NX_READY = 2'd1,
      NX_RERX  = 2'd2,
      NX_SLEEP = 2'd3
   } next_sel_t;

   function automatic logic state_is_busy(seq_state_t s);
      return (s == ST_CAL) || (s == ST_SETTLE) || (s == ST_FRONT) || (s == ST_RX);
   endfunction

endpackage

// File: rtl/rx_seq_settle_timer.sv
module rx_seq_settle_timer #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] len,
   input  logic             run,
   output logic             zero
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= len;
      else if (run && (cnt_q != '0))
         cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);

endmodule

// File: rtl/rx_seq_cal_watch.sv
module rx_seq_cal_watch #(
   parameter int TMO = 1024
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   output logic expire
);

   localparam int W = $clog2(TMO + 1);
   localparam logic [W-1:0] LAST = W'(TMO - 1);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (!active)
         cnt_q <= '0;
      else if (cnt_q != LAST)
         cnt_q <= cnt_q + 1'b1;
   end

   assign expire = active && (cnt_q == LAST);

   // R8
   first_cycle_no_expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(active) |-> !expire);

endmodule

// File: rtl/rx_seq_out_dec.sv
module rx_seq_out_dec
   import rx_seq_pkg::*;
(
   input  seq_state_t state,
   input  logic       kill,
   output logic       synth_en,
   output logic       vco_cal_en,
   output logic       lna_en,
   output logic       mixer_en,
   output logic       adc_en,
   output logic       modem_rx_en
);

   logic [5:0] en_vec;

   always_comb begin
      case (state)
         ST_CAL:    en_vec = 6'b110000;
         ST_SETTLE: en_vec = 6'b100000;
         ST_FRONT:  en_vec = 6'b101110;
         ST_RX:     en_vec = 6'b101111;
         ST_READY:  en_vec = 6'b100000;
         default:   en_vec = 6'b000000;
      endcase
      if (kill)
         en_vec = 6'b000000;
   end

   assign {synth_en, vco_cal_en, lna_en, mixer_en, adc_en, modem_rx_en} = en_vec;

endmodule

// File: rtl/rx_entry_seq.sv
module rx_entry_seq
   import rx_seq_pkg::*;
#(
   parameter int SETTLE_W = 16,
   parameter int CAL_TMO  = 1024
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_req,
   input  logic [1:0]          start_next,
   input  logic [SETTLE_W-1:0] settle_len,
   input  logic                cal_done,
   input  logic                rx_finish,
   input  logic                abort_req,
   output logic                synth_en,
   output logic                vco_cal_en,
   output logic                lna_en,
   output logic                mixer_en,
   output logic                adc_en,
   output logic                modem_rx_en,
   output logic [2:0]          state_o,
   output logic                busy,
   output logic                cmd_err,
   output logic                cal_err
);

   generate
      if (SETTLE_W < 1 || SETTLE_W > 32) begin : g_bad_settle_w
         $error("SETTLE_W must be in 1..32");
      end
      if (CAL_TMO < 2) begin : g_bad_cal_tmo
         $error("CAL_TMO must be at least 2");
      end
   endgenerate

   seq_state_t state_q, state_d;
   next_sel_t  next_q, next_d;
   logic       cmd_err_q, cal_err_q;
   logic       abort_hit, tmr_load, tmr_zero, cal_expire;

   assign busy      = state_is_busy(state_q);
   assign abort_hit = abort_req && (state_q != ST_IDLE);

   always_comb begin
      state_d  = state_q;
      next_d   = next_q;
      tmr_load = 1'b0;
      if (abort_hit) begin
         state_d = ST_IDLE;
      end else begin
         case (state_q)
            ST_IDLE, ST_READY, ST_SLEEP: begin
               if (start_req) begin
                  state_d = ST_CAL;
                  next_d  = next_sel_t'(start_next);
               end
            end
            ST_CAL: begin
               if (cal_done) begin
                  state_d  = ST_SETTLE;
                  tmr_load = 1'b1;
               end else if (cal_expire) begin
                  state_d = ST_IDLE;
               end
            end
            ST_SETTLE: if (tmr_zero) state_d = ST_FRONT;
            ST_FRONT:  state_d = ST_RX;
            ST_RX: begin
               if (rx_finish) begin
                  case (next_q)
                     NX_IDLE:  state_d = ST_IDLE;
                     NX_READY: state_d = ST_READY;
                     NX_RERX:  state_d = ST_CAL;
                     default:  state_d = ST_SLEEP;
                  endcase
               end
            end
            default: state_d = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         next_q    <= NX_IDLE;
         cmd_err_q <= 1'b0;
         cal_err_q <= 1'b0;
      end else begin
         state_q <= state_d;
         next_q  <= next_d;
         if (start_req && busy)
            cmd_err_q <= 1'b1;
         if ((state_q == ST_CAL) && !abort_hit && !cal_done && cal_expire)
            cal_err_q <= 1'b1;
      end
   end

   rx_seq_settle_timer #(.CNT_W(SETTLE_W)) settle_i (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (tmr_load),
      .len   (settle_len),
      .run   (state_q == ST_SETTLE),
      .zero  (tmr_zero)
   );

   rx_seq_cal_watch #(.TMO(CAL_TMO)) calwd_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .active (state_q == ST_CAL),
      .expire (cal_expire)
   );

   rx_seq_out_dec dec_i (
      .state       (state_q),
      .kill        (abort_hit),
      .synth_en    (synth_en),
      .vco_cal_en  (vco_cal_en),
      .lna_en      (lna_en),
      .mixer_en    (mixer_en),
      .adc_en      (adc_en),
      .modem_rx_en (modem_rx_en)
   );

   assign state_o = state_q;
   assign cmd_err = cmd_err_q;
   assign cal_err = cal_err_q;

   // R3
   settle_after_cal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SETTLE && $past(state_q) == ST_CAL) |-> $past(cal_done));

   // R4
   frontend_after_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lna_en) |-> ($past(state_q) == ST_SETTLE));

   // R4
   modem_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(modem_rx_en) |-> ($past(lna_en) && lna_en));

   // R6
   abort_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (abort_req && state_q != ST_IDLE) |=> (state_q == ST_IDLE));

   // R7
   cmd_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_err |=> cmd_err);

   // R8
   cal_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cal_err |=> cal_err);

endmodule

// File: tb/rx_entry_seq_tb_top.sv
module rx_entry_seq_tb_top;

   localparam int SW  = 5;
   localparam int TMO = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_req = 1'b0;
   logic [1:0]    start_next = 2'd0;
   logic [SW-1:0] settle_len = '0;
   logic          cal_done = 1'b0;
   logic          rx_finish = 1'b0;
   logic          abort_req = 1'b0;
   logic synth_en, vco_cal_en, lna_en, mixer_en, adc_en, modem_rx_en;
   logic [2:0] state_o;
   logic busy, cmd_err, cal_err;

   int n_vec = 0;
   int n_bad = 0;

   localparam logic [5:0] EN_OFF   = 6'b000000;
   localparam logic [5:0] EN_CAL   = 6'b110000;
   localparam logic [5:0] EN_SYN   = 6'b100000;
   localparam logic [5:0] EN_FRONT = 6'b101110;
   localparam logic [5:0] EN_RX    = 6'b101111;

   always #4 clk = ~clk;

   rx_entry_seq #(.SETTLE_W(SW), .CAL_TMO(TMO)) dut_i (
      .clk(clk), .rst_n(rst_n), .start_req(start_req), .start_next(start_next),
      .settle_len(settle_len), .cal_done(cal_done), .rx_finish(rx_finish),
      .abort_req(abort_req), .synth_en(synth_en), .vco_cal_en(vco_cal_en),
      .lna_en(lna_en), .mixer_en(mixer_en), .adc_en(adc_en),
      .modem_rx_en(modem_rx_en), .state_o(state_o), .busy(busy),
      .cmd_err(cmd_err), .cal_err(cal_err)
   );

   function automatic logic [5:0] en_now();
      return {synth_en, vco_cal_en, lna_en, mixer_en, adc_en, modem_rx_en};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #2;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      start_req = 0; cal_done = 0; rx_finish = 0; abort_req = 0;
      step(); step();
      rst_n = 1'b1;
      step();
   endtask

   task automatic chk_state(input string req, input logic [2:0] st, input logic [5:0] en);
      check(req, {29'd0, state_o}, {29'd0, st});
      check(req, {26'd0, en_now()}, {26'd0, en});
   endtask

   task automatic issue_start(input logic [1:0] nx);
      start_next = nx;
      start_req  = 1'b1;
      step();
      start_req  = 1'b0;
   endtask

   // drives from calibrate through to receive, checking every phase
   task automatic cal_to_rx(input logic [SW-1:0] len);
      settle_len = len;
      cal_done = 1'b1;
      step();
      cal_done = 1'b0;
      chk_state("R3", 3'd2, EN_SYN);
      for (int i = 0; i < int'(len); i++) begin
         step();
         if (state_o !== 3'd2) chk_state("R3", 3'd2, EN_SYN);
      end
      n_vec++;
      step();
      chk_state("R4", 3'd3, EN_FRONT);
      step();
      chk_state("R4", 3'd4, EN_RX);
      check("R9", {31'd0, busy}, 32'd1);
   endtask

   task automatic t_reset();
      do_reset();
      chk_state("R1", 3'd0, EN_OFF);
      check("R1", {29'd0, busy, cmd_err, cal_err}, 32'd0);
   endtask

   task automatic t_basic_idle();
      do_reset();
      issue_start(2'd0);
      chk_state("R2", 3'd1, EN_CAL);
      check("R9", {31'd0, busy}, 32'd1);
      cal_to_rx(5'd3);
      step();
      chk_state("R5", 3'd4, EN_RX);
      rx_finish = 1'b1;
      step();
      rx_finish = 1'b0;
      chk_state("R5", 3'd0, EN_OFF);
      check("R9", {31'd0, busy}, 32'd0);
   endtask

   task automatic t_settle_edges();
      do_reset();
      issue_start(2'd0);
      cal_to_rx(5'd0);
      do_reset();
      issue_start(2'd0);
      cal_to_rx(5'd31);
   endtask

   task automatic t_ready_then_restart();
      do_reset();
      issue_start(2'd1);
      cal_to_rx(5'd2);
      rx_finish = 1'b1;
      step();
      rx_finish = 1'b0;
      chk_state("R5", 3'd5, EN_SYN);
      check("R9", {31'd0, busy}, 32'd0);
      issue_start(2'd3);
      chk_state("R2", 3'd1, EN_CAL);
      cal_to_rx(5'd1);
      rx_finish = 1'b1;
      step();
      rx_finish = 1'b0;
      chk_state("R5", 3'd6, EN_OFF);
      check("R9", {31'd0, busy}, 32'd0);
      issue_start(2'd0);
      chk_state("R2", 3'd1, EN_CAL);
   endtask

   task automatic t_rerx();
      do_reset();
      issue_start(2'd2);
      cal_to_rx(5'd1);
      rx_finish = 1'b1;
      step();
      rx_finish = 1'b0;
      chk_state("R5", 3'd1, EN_CAL);
      cal_to_rx(5'd0);
   endtask

   task automatic t_finish_ignored();
      do_reset();
      issue_start(2'd0);
      rx_finish = 1'b1;
      step();
      chk_state("R5", 3'd1, EN_CAL);
      rx_finish = 1'b0;
      settle_len = 5'd6;
      cal_done = 1'b1;
      step();
      cal_done = 1'b0;
      rx_finish = 1'b1;
      step();
      rx_finish = 1'b0;
      chk_state("R5", 3'd2, EN_SYN);
   endtask

   task automatic t_abort();
      do_reset();
      issue_start(2'd1);
      settle_len = 5'd9;
      cal_done = 1'b1;
      step();
      cal_done = 1'b0;
      step();
      abort_req = 1'b1;
      #1;
      check("R6", {26'd0, en_now()}, {26'd0, EN_OFF});
      step();
      abort_req = 1'b0;
      chk_state("R6", 3'd0, EN_OFF);
      abort_req = 1'b1;
      step();
      abort_req = 1'b0;
      chk_state("R6", 3'd0, EN_OFF);
      issue_start(2'd1);
      cal_to_rx(5'd0);
      abort_req = 1'b1;
      #1;
      check("R6", {26'd0, en_now()}, {26'd0, EN_OFF});
      step();
      abort_req = 1'b0;
      chk_state("R6", 3'd0, EN_OFF);
   endtask

   task automatic t_busy_start();
      do_reset();
      issue_start(2'd1);
      start_next = 2'd3;
      start_req = 1'b1;
      step();
      start_req = 1'b0;
      chk_state("R7", 3'd1, EN_CAL);
      check("R7", {31'd0, cmd_err}, 32'd1);
      cal_to_rx(5'd1);
      start_next = 2'd0;
      start_req = 1'b1;
      step();
      start_req = 1'b0;
      chk_state("R7", 3'd4, EN_RX);
      rx_finish = 1'b1;
      step();
      rx_finish = 1'b0;
      chk_state("R7", 3'd5, EN_SYN);
      check("R7", {31'd0, cmd_err}, 32'd1);
   endtask

   task automatic t_cal_timeout();
      do_reset();
      issue_start(2'd0);
      for (int i = 0; i < TMO - 1; i++) step();
      chk_state("R8", 3'd1, EN_CAL);
      check("R8", {31'd0, cal_err}, 32'd0);
      step();
      chk_state("R8", 3'd0, EN_OFF);
      check("R8", {31'd0, cal_err}, 32'd1);
      step();
      check("R8", {31'd0, cal_err}, 32'd1);
      do_reset();
      issue_start(2'd0);
      for (int i = 0; i < TMO - 1; i++) step();
      cal_to_rx(5'd0);
      check("R8", {31'd0, cal_err}, 32'd0);
   endtask

   initial begin
      #(8 * 200000);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      t_reset();
      t_basic_idle();
      t_settle_edges();
      t_ready_then_restart();
      t_rerx();
      t_finish_ignored();
      t_abort();
      t_busy_start();
      t_cal_timeout();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule